// File: doc/BRIEF.md
# Event Timer Comparator Channel

This block is one comparator channel of a high-precision event timer. A free-running main counter, shared by all channels and kept outside this block, is presented on an input bus. The channel holds a comparator and a period value. It raises an interrupt when the count reaches the comparator. In one-shot mode the channel then stays quiet until it is re-armed. In periodic mode it advances the comparator by the period until the comparator is ahead of the count again.

A configuration word selects edge or level signalling, periodic operation, a 32-bit operating mode and a set-value flag. While the set-value flag is set, the next comparator write in periodic mode goes to the comparator. Without it, that write goes to the period. In 32-bit one-shot mode the channel also interrupts when the low 32 bits of the count wrap. The comparator and the configuration word can be read back. A status bit records level interrupts until software clears it.

Top module: `evt_cmp_channel`

## Requirements
- R1: After reset the comparator reads all ones, the period is zero, irq and sts are low, and the configuration reads 0x60. Configuration bit 0 selects level (1) or edge (0) signalling, bit 1 enables the channel, bit 2 selects periodic mode, bit 3 is the set-value flag and bit 4 selects 32-bit mode. Bits 6:5 always read as ones (periodic-capable, 64-bit-capable).
- R2: While the channel is active and armed, a match occurs when the signed difference comparator minus count is not positive. A comparator that is already behind therefore matches on the next clock. In one-shot mode, or in periodic mode with a zero period, a match disarms the channel. A comparator write re-arms it, and so does any cycle in which the channel is inactive.
- R3: In periodic mode with a nonzero period, a match adds the period to the comparator. The addition repeats once per clock until the comparator is ahead of the count, and only the first match of the run interrupts.
- R4: In 32-bit mode, comparisons use only the low 32 bits and comparator additions wrap at 32 bits. A configuration write with bit 4 set clears the upper 32 bits of the comparator and the period. Writes to the comparator high half are ignored.
- R5: A comparator write loads the comparator in one-shot mode, or in periodic mode when the set-value flag is set. A low-half write in periodic mode also loads the low half of the period. A high-half write in periodic mode without the set-value flag loads only the period high half.
- R6: Any comparator write clears the set-value flag.
- R7: The most significant bit of a period value (bit 31 in 32-bit mode, bit 63 otherwise) is stored as zero.
- R8: In 32-bit one-shot mode, an armed active channel also interrupts when the low 32 bits of the count decrease from one clock to the next (a wrap). A wrap does not disarm the channel.
- R9: In level mode a match sets sts one clock later, and irq follows sts. Both stay high until sts_clr is sampled high with no new match in that cycle.
- R10: In edge mode a match gives irq high for exactly one clock, one clock after the match, and sts stays low.
- R11: irq and sts are low in any cycle in which glb_en or the channel enable is low, and a held status is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_cnt | input | CNT_W | Shared main counter value |
| glb_en | input | 1 | Global enable for counting and interrupts |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 7 | Configuration write data |
| cmp_lo_we | input | 1 | Comparator low-half write strobe |
| cmp_hi_we | input | 1 | Comparator high-half write strobe |
| cmp_wdata | input | CNT_W/2 | Comparator write data |
| sts_clr | input | 1 | Clear the level status bit |
| cfg_rd | output | 7 | Configuration read-back |
| cmp_rd | output | CNT_W | Comparator read-back |
| irq | output | 1 | Interrupt request |
| sts | output | 1 | Level interrupt status |

## Verification
Matching is tried with counts just before, exactly at and past the comparator. It is also tried with a comparator already behind when the channel is enabled, which separates the signed-difference test from an equality test. Periodic runs with a count far past the comparator show that the catch-up advances several periods and yields one interrupt. A period with its top bit set shows whether the clamp is applied. In 32-bit mode, counts whose upper halves differ from the comparator's separate low-half comparison from full-width comparison, and a comparator addition that crosses 2^32 exposes the wrap. Random comparator and count pairs clustered around the match point check the sign decision across the full 64-bit range.

// File: rtl/evt_cmp_pkg.sv
package evt_cmp_pkg;
  localparam int CFG_W = 7;

  typedef struct packed {
    logic wide_cap;
    logic per_cap;
    logic mode32;
    logic setval;
    logic periodic;
    logic ch_en;
    logic level;
  } chan_cfg_t;

  localparam chan_cfg_t CFG_RST = '{wide_cap: 1'b1, per_cap: 1'b1, default: 1'b0};
endpackage

// File: rtl/evt_cmp_cfg.sv
module evt_cmp_cfg
  import evt_cmp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             cmp_wr,
  output chan_cfg_t        cfg_q
);
  chan_cfg_t cfg_n;
  logic      cfg_upd;

  always_comb begin
    cfg_n = cfg_q;
    if (cfg_we) begin
      cfg_n          = chan_cfg_t'(cfg_wdata);
      cfg_n.wide_cap = 1'b1;
      cfg_n.per_cap  = 1'b1;
    end
    if (cmp_wr) cfg_n.setval = 1'b0;
    cfg_upd = cfg_we | cmp_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= CFG_RST;
    else if (cfg_upd) cfg_q <= cfg_n;
  end

  // R6: a comparator write leaves the set-value flag clear
  p_setval_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_wr |=> !cfg_q.setval);
endmodule

// File: rtl/evt_cmp_core.sv
module evt_cmp_core #(
  parameter int CNT_W = 64,
  localparam int HALF_W = CNT_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              periodic,
  input  logic              setval,
  input  logic              mode32,
  input  logic              trunc,
  input  logic              lo_we,
  input  logic              hi_we,
  input  logic [HALF_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  cmp_q,
  output logic              fire
);
  logic [CNT_W-1:0]  per_q, cmp_n, per_n;
  logic              armed_q, armed_n, chase_q, chase_n;
  logic [HALF_W-1:0] prev_lo_q;
  logic              prev_ok_q;
  logic              wr_any, cmp_ahead, due, per_nz, run, wrap_ev, fire_match;
  logic [CNT_W-1:0]  sum_full, cmp_sum;

  function automatic logic ahead_of(input logic [CNT_W-1:0] c,
                                    input logic [CNT_W-1:0] n,
                                    input logic m32);
    logic [CNT_W-1:0] d;
    d = c - n;
    if (m32) return !d[HALF_W-1] && (d[HALF_W-1:0] != '0);
    else     return !d[CNT_W-1] && (d != '0);
  endfunction

  always_comb begin
    wr_any     = lo_we | hi_we;
    cmp_ahead  = ahead_of(cmp_q, cnt, mode32);
    due        = active & armed_q & ~cmp_ahead;
    per_nz     = mode32 ? (|per_q[HALF_W-1:0]) : (|per_q);
    run        = periodic & per_nz;
    sum_full   = cmp_q + per_q;
    cmp_sum    = mode32 ? {{HALF_W{1'b0}}, sum_full[HALF_W-1:0]} : sum_full;
    wrap_ev    = active & armed_q & mode32 & ~periodic & prev_ok_q &
                 (cnt[HALF_W-1:0] < prev_lo_q);
    fire_match = due & ~chase_q;
    fire       = fire_match | wrap_ev;
  end

  always_comb begin
    cmp_n   = cmp_q;
    per_n   = per_q;
    armed_n = armed_q;
    chase_n = 1'b0;
    if (!active) begin
      armed_n = 1'b1;
    end else if (due) begin
      if (run) begin
        cmp_n   = cmp_sum;
        chase_n = ~ahead_of(cmp_sum, cnt, mode32);
      end else begin
        armed_n = 1'b0;
      end
    end
    if (wr_any) begin
      cmp_n   = cmp_q;
      armed_n = 1'b1;
      chase_n = 1'b0;
      if (lo_we) begin
        if (!periodic || setval) cmp_n[HALF_W-1:0] = wdata;
        if (periodic) begin
          per_n[HALF_W-1:0] = wdata;
          if (mode32) per_n[HALF_W-1] = 1'b0;
        end
      end
      if (hi_we && !mode32) begin
        if (!periodic || setval) cmp_n[CNT_W-1:HALF_W] = wdata;
        else per_n[CNT_W-1:HALF_W] = {1'b0, wdata[HALF_W-2:0]};
      end
    end
    if (trunc) begin
      cmp_n[CNT_W-1:HALF_W] = '0;
      per_n[CNT_W-1:HALF_W] = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q   <= '1;
      per_q   <= '0;
      armed_q <= 1'b1;
      chase_q <= 1'b0;
    end else begin
      cmp_q   <= cmp_n;
      per_q   <= per_n;
      armed_q <= armed_n;
      chase_q <= chase_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_lo_q <= '0;
      prev_ok_q <= 1'b0;
    end else begin
      prev_ok_q <= active;
      if (active) prev_lo_q <= cnt[HALF_W-1:0];
    end
  end

  // R4: in 32-bit mode the comparator upper half stays zero
  p_trunc_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mode32 |-> (cmp_q[CNT_W-1:HALF_W] == '0));
  // R7: the period never holds its top bit
  p_per_msb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    per_q[CNT_W-1] == 1'b0);
  // R2: a non-reloading match disarms the channel
  p_oneshot_disarm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (active && due && !run && !wr_any) |=> !armed_q);
  // R3: a reloading match moves the comparator
  p_reload_moves_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && due && run && !wr_any && !trunc) |=> (cmp_q != $past(cmp_q)));
endmodule

// File: rtl/evt_cmp_irq.sv
module evt_cmp_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic level,
  input  logic fire,
  input  logic sts_clr,
  output logic irq,
  output logic sts
);
  logic sts_q, sts_n, pulse_q, pulse_n;

  always_comb begin
    if (!active || !level) sts_n = 1'b0;
    else if (fire)         sts_n = 1'b1;
    else if (sts_clr)      sts_n = 1'b0;
    else                   sts_n = sts_q;
    pulse_n = active & ~level & fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      sts_q   <= sts_n;
      pulse_q <= pulse_n;
    end
  end

  assign irq = active & (level ? sts_q : pulse_q);
  assign sts = active & sts_q;

  // R9: a level match sets the status
  p_level_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && level && fire) |=> sts_q);
  // R9: status holds until cleared
  p_level_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q && active && level && !sts_clr) |=> sts_q);
  // R10: edge mode never records status
  p_edge_nosts_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !level |=> !sts_q);
  // R11: an inactive channel drops all pending state
  p_off_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (!sts_q && !pulse_q));
endmodule

// File: rtl/evt_cmp_channel.sv
module evt_cmp_channel
  import evt_cmp_pkg::*;
#(
  parameter int CNT_W = 64,
  localparam int HALF_W = CNT_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  main_cnt,
  input  logic              glb_en,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              cmp_lo_we,
  input  logic              cmp_hi_we,
  input  logic [HALF_W-1:0] cmp_wdata,
  input  logic              sts_clr,
  output logic [CFG_W-1:0]  cfg_rd,
  output logic [CNT_W-1:0]  cmp_rd,
  output logic              irq,
  output logic              sts
);
  chan_cfg_t cfg_q, cfg_wr_view;
  logic      active, cmp_wr, trunc, fire;

  assign cfg_wr_view = chan_cfg_t'(cfg_wdata);
  assign active      = glb_en & cfg_q.ch_en;
  assign cmp_wr      = cmp_lo_we | cmp_hi_we;
  assign trunc       = cfg_we & cfg_wr_view.mode32;

  evt_cmp_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cmp_wr(cmp_wr), .cfg_q(cfg_q)
  );

  evt_cmp_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .active(active), .periodic(cfg_q.periodic),
    .setval(cfg_q.setval), .mode32(cfg_q.mode32), .trunc(trunc),
    .lo_we(cmp_lo_we), .hi_we(cmp_hi_we), .wdata(cmp_wdata), .cnt(main_cnt),
    .cmp_q(cmp_rd), .fire(fire)
  );

  evt_cmp_irq u_irq (
    .clk(clk), .rst_n(rst_n), .active(active), .level(cfg_q.level),
    .fire(fire), .sts_clr(sts_clr), .irq(irq), .sts(sts)
  );

  assign cfg_rd = cfg_q;
endmodule

// File: tb/evt_cmp_channel_tb_top.sv
`timescale 1ns/1ps
module evt_cmp_channel_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] main_cnt = '0;
  logic        glb_en = 1'b0;
  logic        cfg_we = 1'b0;
  logic [6:0]  cfg_wdata = '0;
  logic        cmp_lo_we = 1'b0;
  logic        cmp_hi_we = 1'b0;
  logic [31:0] cmp_wdata = '0;
  logic        sts_clr = 1'b0;
  logic [6:0]  cfg_rd;
  logic [63:0] cmp_rd;
  logic        irq, sts;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  evt_cmp_channel dut_i (
    .clk(clk), .rst_n(rst_n), .main_cnt(main_cnt), .glb_en(glb_en),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cmp_lo_we(cmp_lo_we),
    .cmp_hi_we(cmp_hi_we), .cmp_wdata(cmp_wdata), .sts_clr(sts_clr),
    .cfg_rd(cfg_rd), .cmp_rd(cmp_rd), .irq(irq), .sts(sts)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk); endtask
  task automatic wr_cfg(input logic [6:0] v);
    @(negedge clk); cfg_wdata = v; cfg_we = 1'b1;
    @(negedge clk); cfg_we = 1'b0;
  endtask
  task automatic wr_lo(input logic [31:0] v);
    @(negedge clk); cmp_wdata = v; cmp_lo_we = 1'b1;
    @(negedge clk); cmp_lo_we = 1'b0;
  endtask
  task automatic wr_hi(input logic [31:0] v);
    @(negedge clk); cmp_wdata = v; cmp_hi_we = 1'b1;
    @(negedge clk); cmp_hi_we = 1'b0;
  endtask
  task automatic drv_cnt(input logic [63:0] v); @(negedge clk); main_cnt = v; endtask
  task automatic drv_en(input logic e); @(negedge clk); glb_en = e; endtask
  task automatic drv_both(input logic [63:0] v, input logic e);
    @(negedge clk); main_cnt = v; glb_en = e;
  endtask
  task automatic clr_sts();
    @(negedge clk); sts_clr = 1'b1;
    @(negedge clk); sts_clr = 1'b0;
  endtask

  function automatic logic exp_match64(input logic [63:0] c, input logic [63:0] n);
    logic [63:0] d;
    d = c - n;
    return !(!d[63] && d != 64'd0);
  endfunction

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    int pulses;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc();
    // R1 reset state
    chk("R1 cfg", {57'd0, cfg_rd}, 64'h60);
    chk("R1 cmp", cmp_rd, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R1 irq", {63'd0, irq}, 64'd0);
    chk("R1 sts", {63'd0, sts}, 64'd0);

    // R11: configured and due, but globally disabled
    wr_cfg(7'h03); wr_hi(32'd0); wr_lo(32'd100);
    drv_cnt(64'd500); cyc(); cyc();
    chk("R11 irq off", {63'd0, irq}, 64'd0);
    chk("R11 sts off", {63'd0, sts}, 64'd0);

    // R2 / R9: one-shot level match
    drv_cnt(64'd0); drv_en(1'b1); cyc();
    chk("R2 ahead no irq", {63'd0, irq}, 64'd0);
    drv_cnt(64'd99); cyc();
    chk("R2 one before", {63'd0, irq}, 64'd0);
    drv_cnt(64'd100); cyc();
    chk("R2 match irq", {63'd0, irq}, 64'd1);
    chk("R9 sts set", {63'd0, sts}, 64'd1);
    cyc(); cyc();
    chk("R9 held", {63'd0, irq}, 64'd1);
    drv_en(1'b0); #1;
    chk("R11 drop irq", {63'd0, irq}, 64'd0);
    chk("R11 drop sts", {63'd0, sts}, 64'd0);
    drv_cnt(64'd200); wr_lo(32'd50); drv_en(1'b1); cyc();
    chk("R2 behind fires", {63'd0, sts}, 64'd1);
    clr_sts();
    chk("R9 cleared", {63'd0, sts}, 64'd0);
    cyc(); cyc();
    chk("R2 once only", {63'd0, irq}, 64'd0);

    // R10 edge pulse
    wr_cfg(7'h02); wr_lo(32'd300);
    drv_cnt(64'd300); cyc();
    chk("R10 pulse", {63'd0, irq}, 64'd1);
    chk("R10 no sts", {63'd0, sts}, 64'd0);
    cyc();
    chk("R10 one cycle", {63'd0, irq}, 64'd0);

    // R5 / R6 / R3 periodic
    wr_cfg(7'h0F);
    chk("R1 cfg layout", {57'd0, cfg_rd}, 64'h6F);
    wr_lo(32'd1000);
    chk("R6 setval cleared", {57'd0, cfg_rd}, 64'h67);
    chk("R5 setval loads cmp", cmp_rd, 64'd1000);
    wr_hi(32'd0);
    chk("R5 hi goes to period", cmp_rd, 64'd1000);
    drv_cnt(64'd1000); cyc();
    chk("R3 periodic irq", {63'd0, sts}, 64'd1);
    chk("R3 reload", cmp_rd, 64'd2000);
    clr_sts();
    wr_cfg(7'h06);
    drv_cnt(64'd5500);
    pulses = 0;
    for (int i = 0; i < 6; i++) begin
      cyc();
      if (irq) pulses++;
    end
    chk("R3 single irq in catch-up", pulses, 1);
    chk("R3 catch-up cmp", cmp_rd, 64'd6000);

    // R7 period clamp, 64-bit
    wr_lo(32'hFFFF_FFFF);
    chk("R5 lo periodic keeps cmp", cmp_rd, 64'd6000);
    wr_hi(32'hFFFF_FFFF);
    drv_cnt(64'd6000); cyc();
    chk("R7 fire", {63'd0, irq}, 64'd1);
    chk("R7 clamp64", cmp_rd, 64'd6000 + 64'h7FFF_FFFF_FFFF_FFFF);

    // R4 32-bit mode
    drv_en(1'b0);
    wr_cfg(7'h16);
    chk("R4 truncate", cmp_rd, 64'h176F);
    wr_cfg(7'h1E);
    wr_lo(32'h8000_0010);
    chk("R5 setval lo", cmp_rd, 64'h8000_0010);
    wr_hi(32'h0000_ABCD);
    chk("R4 hi ignored", cmp_rd, 64'h8000_0010);
    drv_both(64'h5_8000_0000, 1'b1); cyc();
    chk("R4 ahead low half", {63'd0, irq}, 64'd0);
    drv_cnt(64'h5_8000_0010); cyc();
    chk("R4 low-half match", {63'd0, irq}, 64'd1);
    chk("R7 clamp32", cmp_rd, 64'h8000_0020);
    drv_en(1'b0);
    wr_cfg(7'h1E); wr_lo(32'hFFFF_FFF8); wr_lo(32'h10);
    drv_both(64'h5_FFFF_FFF0, 1'b1); cyc();
    chk("R4 no early", {63'd0, irq}, 64'd0);
    drv_cnt(64'h5_FFFF_FFF8); cyc();
    chk("R4 fire", {63'd0, irq}, 64'd1);
    chk("R4 add wraps", cmp_rd, 64'h8);

    // R8 wrap interrupt
    drv_en(1'b0);
    wr_cfg(7'h12); wr_lo(32'h100);
    drv_both(64'h0_FFFF_FFF0, 1'b1); cyc();
    chk("R8 quiet before wrap", {63'd0, irq}, 64'd0);
    drv_cnt(64'h1_0000_0005); cyc();
    chk("R8 wrap irq", {63'd0, irq}, 64'd1);
    cyc();
    chk("R8 wrap once", {63'd0, irq}, 64'd0);
    drv_cnt(64'h1_0000_0100); cyc();
    chk("R8 match after wrap", {63'd0, irq}, 64'd1);

    // R2 random 64-bit one-shot sign decisions
    drv_en(1'b0);
    wr_cfg(7'h02);
    for (int k = 0; k < 24; k++) begin
      logic [63:0] c, n;
      logic [31:0] sel;
      c = {$urandom(), $urandom()};
      sel = $urandom() % 4;
      case (sel)
        0: n = c - 64'($urandom() % 16);
        1: n = c + 64'($urandom() % 16);
        2: n = c;
        default: n = {$urandom(), $urandom()};
      endcase
      wr_hi(c[63:32]); wr_lo(c[31:0]);
      chk("R2 random cmp load", cmp_rd, c);
      drv_both(n, 1'b1); cyc();
      chk("R2 random match", {63'd0, irq}, {63'd0, exp_match64(c, n)});
      drv_en(1'b0);
    end

    finish_run();
  end
endmodule